// File: doc/BRIEF.md
# Hashed Layer-2 Address Lookup Engine

This block finds a 48-bit layer-2 address by exact match in a small on-chip table. The key is folded by XOR into a bucket index. The engine then reads that bucket's slots one per clock, in slot order, comparing each stored address with the key. The walk stops at the first match, at the first empty slot, or after the last slot. A lookup therefore takes between one cycle and the bucket depth in cycles, depending on how full the bucket is. Each result reports how many slots were read, so a caller can see the latency it paid.

Keys enter through a valid/ready request stream, and results leave through a valid/ready result stream. The engine handles one lookup at a time. `req_ready` is high only while the engine is idle. Once a result is presented, it stays unchanged until `res_ready` is sampled high; while the result waits, no new request is accepted.

Entries are added through a plain one-cycle insert port. An insert hashes its key the same way and writes the lowest free slot of that bucket. One cycle later it reports either success or that the bucket was full.

Top module: `mac_hash_lookup`

## Requirements
- R1: The bucket index of a key is the XOR of its eight 6-bit chunks (key bits [5:0] ^ [11:6] ^ ... ^ [47:42]); inserts and lookups of the same key always reach the same bucket.
- R2: After reset, `req_ready` is 1, `res_valid` is 0 and `ins_ack` is 0. `req_ready` is 1 only while no lookup is in progress or waiting to be taken.
- R3: When the key is found, the result has `res_hit`=1 and the data of the lowest-numbered matching slot (a duplicate key in a later slot is never returned), with `res_reads` = that slot number + 1.
- R4: When the walk reaches an empty slot before any match, the result is a miss (`res_hit`=0, `res_data`=0) with `res_reads` = number of occupied slots + 1.
- R5: When a full bucket holds no match, the result is a miss with `res_reads` = bucket depth (4).
- R6: The engine reads one slot per clock. `res_valid` rises exactly `res_reads` clock edges after the edge that accepted the request.
- R7: While `res_valid`=1 and `res_ready`=0, `res_hit`, `res_data` and `res_reads` hold their values and `req_ready` stays 0. The edge that sees `res_ready`=1 takes the result and returns the engine to idle.
- R8: An insert pulse (`ins_en`=1 for one cycle) writes key and data into the lowest free slot of its bucket. `ins_ack`=1 with `ins_full`=0 follows in the next cycle.
- R9: An insert into a full bucket gives `ins_ack`=1 with `ins_full`=1 and leaves the table unchanged, so the key then looks up as a miss.
- R10: Reset empties every slot, so any lookup after reset misses with `res_reads`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup key offered |
| req_ready | output | 1 | Engine idle, key taken when valid |
| req_key | input | 48 | Address to look up |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_hit | output | 1 | Key was found |
| res_data | output | 16 | Stored data on hit, zero on miss |
| res_reads | output | 3 | Slots read during this lookup |
| ins_en | input | 1 | Insert strobe |
| ins_key | input | 48 | Address to insert |
| ins_data | input | 16 | Data stored with the address |
| ins_ack | output | 1 | Insert finished (one cycle after strobe) |
| ins_full | output | 1 | With ins_ack: bucket was full, nothing written |

## Verification
Lookups are tried against three kinds of bucket: one partly filled, one full and one empty. Partial buckets are probed with keys at every slot position and with an absent key, which separates a match at a given depth from an early stop at an empty slot. Full buckets are probed with both a last-slot hit and an absent key, which separates a hit found at the final slot from running off the end. A duplicate insert shows that the first match wins. Back-pressure on the result stream shows that results hold steady and requests are refused.

// File: rtl/mac_hash_pkg.sv
package mac_hash_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } walk_st_e;
endpackage

// File: rtl/mac_fold_hash.sv
module mac_fold_hash #(
  parameter int KEY_W = 48,
  parameter int PTR_W = 6
) (
  input  logic [KEY_W-1:0] key,
  output logic [PTR_W-1:0] bucket
);
  localparam int NCHUNK = (KEY_W + PTR_W - 1) / PTR_W;
  localparam int PAD_W  = NCHUNK * PTR_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(key);

  always_comb begin
    bucket = '0;
    for (int c = 0; c < NCHUNK; c++)
      bucket = bucket ^ padded[c*PTR_W +: PTR_W];
  end
endmodule

// File: rtl/mac_bucket_mem.sv
module mac_bucket_mem #(
  parameter int KEY_W  = 48,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PTR_W-1:0]           rd_bucket,
  input  logic [$clog2(DEPTH)-1:0]   rd_slot,
  output logic                       rd_valid,
  output logic [KEY_W-1:0]           rd_key,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_bucket,
  input  logic [KEY_W-1:0]           wr_key,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       wr_ack,
  output logic                       wr_full
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int IDX_W  = PTR_W + SLOT_W;
  localparam int NENT   = (1 << PTR_W) * DEPTH;

  logic [NENT-1:0]   valid_q;
  logic [KEY_W-1:0]  key_mem  [NENT];
  logic [DATA_W-1:0] data_mem [NENT];

  logic              free_found;
  logic [SLOT_W-1:0] free_slot;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign rd_idx   = {rd_bucket, rd_slot};
  assign rd_valid = valid_q[rd_idx];
  assign rd_key   = key_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (!valid_q[{wr_bucket, SLOT_W'(s)}]) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(s);
      end
    end
  end

  assign wr_idx = {wr_bucket, free_slot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wr_ack  <= 1'b0;
      wr_full <= 1'b0;
    end else begin
      wr_ack  <= wr_en;
      wr_full <= wr_en && !free_found;
      if (wr_en && free_found)
        valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && free_found) begin
      key_mem[wr_idx]  <= wr_key;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // R8
  ins_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ack);

  // R9
  full_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !free_found |=> wr_full && valid_q == $past(valid_q));
endmodule

// File: rtl/mac_walk_ctrl.sv
module mac_walk_ctrl
  import mac_hash_pkg::*;
#(
  parameter int KEY_W  = 48,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [KEY_W-1:0]             req_key,
  input  logic [PTR_W-1:0]             req_bucket,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic                         res_hit,
  output logic [DATA_W-1:0]            res_data,
  output logic [$clog2(DEPTH+1)-1:0]   res_reads,
  output logic [PTR_W-1:0]             rd_bucket,
  output logic [$clog2(DEPTH)-1:0]     rd_slot,
  input  logic                         rd_valid,
  input  logic [KEY_W-1:0]             rd_key,
  input  logic [DATA_W-1:0]            rd_data
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  walk_st_e          st_q;
  logic [KEY_W-1:0]  key_q;
  logic [PTR_W-1:0]  bkt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  reads_now;
  logic              last_slot, finish;

  assign rd_bucket = bkt_q;
  assign rd_slot   = slot_q;
  assign req_ready = (st_q == ST_IDLE);
  assign res_valid = (st_q == ST_DONE);
  assign reads_now = CNT_W'(slot_q) + CNT_W'(1);
  assign last_slot = (slot_q == SLOT_W'(DEPTH - 1));
  assign finish    = !rd_valid || (rd_key == key_q) || last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      key_q     <= '0;
      bkt_q     <= '0;
      slot_q    <= '0;
      res_hit   <= 1'b0;
      res_data  <= '0;
      res_reads <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          key_q  <= req_key;
          bkt_q  <= req_bucket;
          slot_q <= '0;
          st_q   <= ST_WALK;
        end
        ST_WALK: begin
          if (finish) begin
            res_hit   <= rd_valid && (rd_key == key_q);
            res_data  <= (rd_valid && (rd_key == key_q)) ? rd_data : '0;
            res_reads <= reads_now;
            st_q      <= ST_DONE;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit)
      && $stable(res_data) && $stable(res_reads) && !req_ready);

  // R6
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WALK && !finish |=> st_q == ST_WALK && slot_q == $past(slot_q) + SLOT_W'(1));

  // R5
  reads_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_reads >= CNT_W'(1) && res_reads <= CNT_W'(DEPTH));

  // R4
  miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_data == '0);
endmodule

// File: rtl/mac_hash_lookup.sv
module mac_hash_lookup #(
  parameter int KEY_W  = 48,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [KEY_W-1:0]           req_key,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic                       res_hit,
  output logic [DATA_W-1:0]          res_data,
  output logic [$clog2(DEPTH+1)-1:0] res_reads,
  input  logic                       ins_en,
  input  logic [KEY_W-1:0]           ins_key,
  input  logic [DATA_W-1:0]          ins_data,
  output logic                       ins_ack,
  output logic                       ins_full
);
  localparam int SLOT_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  req_bucket, ins_bucket, rd_bucket;
  logic [SLOT_W-1:0] rd_slot;
  logic              rd_valid;
  logic [KEY_W-1:0]  rd_key;
  logic [DATA_W-1:0] rd_data;

  mac_fold_hash #(.KEY_W(KEY_W), .PTR_W(PTR_W)) u_hash_req (
    .key(req_key), .bucket(req_bucket));

  mac_fold_hash #(.KEY_W(KEY_W), .PTR_W(PTR_W)) u_hash_ins (
    .key(ins_key), .bucket(ins_bucket));

  mac_bucket_mem #(.KEY_W(KEY_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_bucket(rd_bucket), .rd_slot(rd_slot),
    .rd_valid(rd_valid), .rd_key(rd_key), .rd_data(rd_data),
    .wr_en(ins_en), .wr_bucket(ins_bucket), .wr_key(ins_key), .wr_data(ins_data),
    .wr_ack(ins_ack), .wr_full(ins_full));

  mac_walk_ctrl #(.KEY_W(KEY_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .DEPTH(DEPTH)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
    .req_bucket(req_bucket),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_data(res_data), .res_reads(res_reads),
    .rd_bucket(rd_bucket), .rd_slot(rd_slot),
    .rd_valid(rd_valid), .rd_key(rd_key), .rd_data(rd_data));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid);

  // R6
  accept_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !res_valid);
endmodule

// File: tb/sim_mac_hash_lookup.sv
module sim_mac_hash_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_key = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_hit;
  logic [15:0] res_data;
  logic [2:0]  res_reads;
  logic        ins_en = 1'b0;
  logic [47:0] ins_key = '0;
  logic [15:0] ins_data = '0;
  logic        ins_ack, ins_full;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mac_hash_lookup u0 (.*);

  typedef struct packed {
    logic [15:0] hi;
    logic [5:0]  bkt;
    logic        hit;
    logic [15:0] data;
    logic [2:0]  reads;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd1,  6'd9,  1'b1, 16'h1111, 3'd1},  // R3
    '{16'd2,  6'd9,  1'b1, 16'h2222, 3'd2},  // R3
    '{16'd3,  6'd9,  1'b1, 16'h3333, 3'd3},  // R3
    '{16'd4,  6'd9,  1'b0, 16'h0000, 3'd4},  // R4
    '{16'd10, 6'd20, 1'b1, 16'h00A0, 3'd1},  // R1
    '{16'd13, 6'd20, 1'b1, 16'h00A3, 3'd4},  // R3
    '{16'd14, 6'd20, 1'b0, 16'h0000, 3'd4},  // R5 R9
    '{16'd7,  6'd33, 1'b0, 16'h0000, 3'd1}   // R4
  };

  function automatic logic [5:0] fold6(input logic [47:0] k);
    logic [5:0] h = '0;
    for (int c = 0; c < 8; c++) h = h ^ k[c*6 +: 6];
    return h;
  endfunction

  function automatic logic [47:0] key_in(input logic [15:0] hi, input logic [5:0] b);
    logic [47:0] k = {hi, 32'h0};
    k[5:0] = fold6(k) ^ b;
    return k;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_insert(input logic [47:0] k, input logic [15:0] d,
                           input logic exp_full, input string tag);
    @(negedge clk);
    ins_en = 1'b1; ins_key = k; ins_data = d;
    @(negedge clk);
    ins_en = 1'b0;
    check({31'd0, ins_ack}, 32'd1, {tag, " R8 ack"});
    check({31'd0, ins_full}, {31'd0, exp_full}, {tag, " full flag"});
  endtask

  task automatic do_lookup(input logic [47:0] k, input logic exp_hit,
                           input logic [15:0] exp_data, input logic [2:0] exp_reads,
                           input string tag);
    int n = 0;
    @(negedge clk);
    check({31'd0, req_ready}, 32'd1, {tag, " R2 ready idle"});
    req_valid = 1'b1; req_key = k;
    @(negedge clk);
    req_valid = 1'b0;
    check({31'd0, req_ready}, 32'd0, {tag, " R2 busy"});
    while (!res_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n, {29'd0, exp_reads}, {tag, " R6 latency"});
    check({31'd0, res_hit}, {31'd0, exp_hit}, {tag, " hit"});
    check({16'd0, res_data}, {16'd0, exp_data}, {tag, " data"});
    check({29'd0, res_reads}, {29'd0, exp_reads}, {tag, " reads"});
    @(negedge clk);
    @(negedge clk);
    // R7 result held under back-pressure
    check({29'd0, res_valid, res_hit, req_ready}, {29'd0, 1'b1, exp_hit, 1'b0}, {tag, " R7 hold"});
    check({13'd0, res_reads, res_data}, {13'd0, exp_reads, exp_data}, {tag, " R7 stable"});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check({30'd0, res_valid, req_ready}, 32'd1, {tag, " R7 release"});
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({29'd0, req_ready, res_valid, ins_ack}, 32'b100, "R2 reset state");
    rst_n = 1'b1;
    check({26'd0, fold6(key_in(16'd5, 6'd17))}, 32'd17, "R1 key builder");

    do_lookup(key_in(16'd1, 6'd9), 1'b0, 16'h0, 3'd1, "R10 empty table");

    do_insert(key_in(16'd1, 6'd9), 16'h1111, 1'b0, "R8 b9 s0");
    do_insert(key_in(16'd2, 6'd9), 16'h2222, 1'b0, "R8 b9 s1");
    do_insert(key_in(16'd3, 6'd9), 16'h3333, 1'b0, "R8 b9 s2");
    for (int i = 0; i < 4; i++)
      do_insert(key_in(16'(10 + i), 6'd20), 16'(16'hA0 + i), 1'b0, "R8 b20");
    do_insert(key_in(16'd14, 6'd20), 16'hBEEF, 1'b1, "R9 overflow");

    for (int v = 0; v < 8; v++)
      do_lookup(key_in(VECS[v].hi, VECS[v].bkt), VECS[v].hit, VECS[v].data,
                VECS[v].reads, $sformatf("R1 vec%0d", v));

    // R3 duplicate key in a later slot does not shadow the first
    do_insert(key_in(16'd2, 6'd9), 16'h9999, 1'b0, "R8 dup");
    do_lookup(key_in(16'd2, 6'd9), 1'b1, 16'h2222, 3'd2, "R3 first match");
    do_lookup(key_in(16'd4, 6'd9), 1'b0, 16'h0, 3'd4, "R5 full miss");
    do_lookup(key_in(16'd2, 6'd9) ^ 48'h1, 1'b0, 16'h0, 3'd1, "R1 other bucket");

    // R10 reset empties table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_lookup(key_in(16'd1, 6'd9), 1'b0, 16'h0, 3'd1, "R10 after reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule